// File: doc/BRIEF.md
# USB OTG Bus Event Interrupt Register

This block watches the decoded USB line state and the OTG session status signals of one port and turns bus happenings into sticky flags in a 16-bit status register. It times how long the bus stays in SE0 and how long it stays idle (J). A long enough idle run puts the port into a suspend state. A J-to-K change seen while suspended is reported as resume. It also flags a session request (SRP), an OTG timer expiry, and every toggle of the remote-connect, B-session-valid and A-session-valid inputs.

Software reads the flags through a small register port and clears them by writing ones. An enable register selects which flags may raise the level-sensitive interrupt output. The register port is plain control: a write strobe, one address bit and a combinational read path. It has no handshake and applies no back-pressure, so every write takes effect on the clock edge where the strobe is sampled. The dwell limits are set in clock cycles, derived from a cycles-per-microsecond parameter and the two microsecond thresholds.

Top module: `usbev_irq_reg`

## Requirements
- R1: After reset the status and enable registers are zero and `irq` is low. Bits 15..11 and 2..0 always read as zero at both addresses.
- R2: A write to address 0 clears each event bit whose write-data bit is 1. Bits whose write-data bit is 0 are unchanged.
- R3: If an event arrives on the same clock edge as a clearing write to its bit, the bit stays set.
- R4: Line state encoding: 0 is SE0, 1 is J, 2 is K, 3 is SE1. Bit 9 sets on the (SE0_CYC+1)-th consecutive sampled SE0 cycle, with SE0_CYC = CYC_PER_US*SE0_US. Any other line state restarts the count, and one run sets the bit at most once.
- R5: Bit 6 sets on the (IDLE_CYC+1)-th consecutive sampled J cycle, with IDLE_CYC = CYC_PER_US*IDLE_US. On that edge the port enters suspend.
- R6: Bit 7 sets only when the line goes from J on one sampled cycle to K on the next while the port is suspended. The same change while not suspended sets nothing.
- R7: Any line state other than J leaves suspend. Staying in J after entry raises no further suspend event, and a new idle run after leaving raises one again.
- R8: Bit 8 sets on a `vbus_pulse` strobe when `srp_sel_dline` is 0, and on a `dline_pulse` strobe when it is 1. The unselected strobe has no effect.
- R9: Bits 5, 4 and 3 set when `rconn`, `bsess_vld` and `asess_vld` toggle in either direction. The first sampled cycle after reset only captures these inputs and never flags.
- R10: Bit 10 sets on an `otg_tmr_expire` strobe.
- R11: A write to address 1 loads the enable register; only bits 10..3 are stored. `irq` is high exactly when some status bit and its enable bit are both set.
- R12: `reg_rdata` shows the status register when `reg_addr` is 0 and the enable register when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_st | input | 2 | Decoded line state (0 SE0, 1 J, 2 K, 3 SE1) |
| vbus_pulse | input | 1 | VBUS pulsing seen (strobe) |
| dline_pulse | input | 1 | Data-line pulsing seen (strobe) |
| srp_sel_dline | input | 1 | SRP type select: 1 data-line, 0 VBUS |
| rconn | input | 1 | Remote device connected status |
| bsess_vld | input | 1 | B-session valid status |
| asess_vld | input | 1 | A-session valid status |
| otg_tmr_expire | input | 1 | OTG timer expiry strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status, 1 enable |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| irq | output | 1 | Level interrupt request |

## Verification
Every event and every register write lands on the first clock edge that samples it. The flag, the enable value and `irq` can be seen one edge after the stimulus, and `reg_rdata` follows `reg_addr` in the same cycle. The dwell flags appear on the edge that samples the (limit+1)-th consecutive SE0 or J cycle. The bench drives inputs just after the rising edge, advances a behavioural reference model on each rising edge, and compares read data and `irq` to that model at every falling edge. Directed checks count edges explicitly and read the status just below each threshold and just above it.

// File: rtl/usbev_pkg.sv
package usbev_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'd0,
    LS_J   = 2'd1,
    LS_K   = 2'd2,
    LS_SE1 = 2'd3
  } line_t;

  localparam int REG_W    = 16;
  localparam int B_ASESS  = 3;
  localparam int B_BSESS  = 4;
  localparam int B_RCONN  = 5;
  localparam int B_SUSP   = 6;
  localparam int B_RESUME = 7;
  localparam int B_SRP    = 8;
  localparam int B_SE0    = 9;
  localparam int B_TMR    = 10;
  localparam logic [REG_W-1:0] EVT_MASK = 16'h07F8;
  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_MASK = 1'b1;
endpackage

// File: rtl/usbev_dwell_timer.sv
module usbev_dwell_timer #(
  parameter int LIMIT = 96000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic fire
);
  localparam int W = $clog2(LIMIT + 2);
  localparam logic [W-1:0] LIM_V = W'(LIMIT);
  localparam logic [W-1:0] SAT_V = W'(LIMIT + 1);

  logic [W-1:0] cnt_q;

  assign fire = cond && (cnt_q == LIM_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!cond) begin
      cnt_q <= '0;
    end else if (cnt_q != SAT_V) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/usbev_linemon.sv
module usbev_linemon import usbev_pkg::*; #(
  parameter int SE0_CYC  = 96000,
  parameter int IDLE_CYC = 144000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  line_t line,
  output logic  se0_evt,
  output logic  susp_evt,
  output logic  resume_evt,
  output logic  in_susp
);
  line_t prev_q;
  logic  susp_q;

  usbev_dwell_timer #(.LIMIT(SE0_CYC)) u_se0_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .cond (line == LS_SE0),
    .fire (se0_evt)
  );

  usbev_dwell_timer #(.LIMIT(IDLE_CYC)) u_idle_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .cond (line == LS_J),
    .fire (susp_evt)
  );

  assign resume_evt = susp_q && (prev_q == LS_J) && (line == LS_K);
  assign in_susp    = susp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= LS_J;
      susp_q <= 1'b0;
    end else begin
      prev_q <= line;
      if (susp_evt) begin
        susp_q <= 1'b1;
      end else if (line != LS_J) begin
        susp_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/usbev_toggle_det.sv
module usbev_toggle_det #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] vec,
  output logic [N-1:0] chg
);
  logic [N-1:0] prev_q;
  logic         primed_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign chg[i] = primed_q && (vec[i] ^ prev_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= vec;
      primed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/usbev_irq_reg.sv
module usbev_irq_reg import usbev_pkg::*; #(
  parameter int CYC_PER_US = 48,
  parameter int SE0_US     = 2000,
  parameter int IDLE_US    = 3000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  line_st,
  input  logic        vbus_pulse,
  input  logic        dline_pulse,
  input  logic        srp_sel_dline,
  input  logic        rconn,
  input  logic        bsess_vld,
  input  logic        asess_vld,
  input  logic        otg_tmr_expire,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq
);
  localparam int SE0_CYC  = CYC_PER_US * SE0_US;
  localparam int IDLE_CYC = CYC_PER_US * IDLE_US;
  localparam int N_STS    = 3;

  line_t            line;
  logic             se0_evt, susp_evt, resume_evt, in_susp;
  logic [N_STS-1:0] chg;
  logic             srp_evt;
  logic [REG_W-1:0] evt_vec, clr_vec, stat_q, en_q;

  assign line = line_t'(line_st);

  usbev_linemon #(.SE0_CYC(SE0_CYC), .IDLE_CYC(IDLE_CYC)) u_linemon (
    .clk       (clk),
    .rst_n     (rst_n),
    .line      (line),
    .se0_evt   (se0_evt),
    .susp_evt  (susp_evt),
    .resume_evt(resume_evt),
    .in_susp   (in_susp)
  );

  usbev_toggle_det #(.N(N_STS)) u_toggle (
    .clk  (clk),
    .rst_n(rst_n),
    .vec  ({rconn, bsess_vld, asess_vld}),
    .chg  (chg)
  );

  assign srp_evt = srp_sel_dline ? dline_pulse : vbus_pulse;

  always_comb begin
    evt_vec           = '0;
    evt_vec[B_TMR]    = otg_tmr_expire;
    evt_vec[B_SE0]    = se0_evt;
    evt_vec[B_SRP]    = srp_evt;
    evt_vec[B_RESUME] = resume_evt;
    evt_vec[B_SUSP]   = susp_evt;
    evt_vec[B_RCONN]  = chg[2];
    evt_vec[B_BSESS]  = chg[1];
    evt_vec[B_ASESS]  = chg[0];
  end

  assign clr_vec = (reg_wr && reg_addr == ADDR_STAT) ? (reg_wdata & EVT_MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_vec) | evt_vec;
      if (reg_wr && reg_addr == ADDR_MASK) begin
        en_q <= reg_wdata & EVT_MASK;
      end
    end
  end

  assign reg_rdata = (reg_addr == ADDR_MASK) ? en_q : stat_q;
  assign irq       = |(stat_q & en_q);
endmodule

// File: rtl/usbev_irq_chk.sv
module usbev_irq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic [15:0] reg_rdata,
  input logic [15:0] stat_q,
  input logic [15:0] en_q,
  input logic [15:0] evt_vec,
  input logic [15:0] clr_vec,
  input logic        susp_evt,
  input logic        in_susp
);
  p_rsv_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~16'h07F8) == 16'h0000);

  p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q != 16'h0000) |=> ((($past(stat_q) & ~$past(clr_vec)) & ~stat_q) == 16'h0000));

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != 16'h0000) |=> (($past(clr_vec) & ~$past(evt_vec) & stat_q) == 16'h0000));

  p_evt_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec != 16'h0000) |=> (($past(evt_vec) & ~stat_q) == 16'h0000));

  p_se0_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vec[9] |=> !evt_vec[9]);

  p_susp_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    susp_evt |-> !in_susp);

  p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ((stat_q & en_q) != 16'h0000));
endmodule

bind usbev_irq_reg usbev_irq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq),
  .reg_rdata(reg_rdata),
  .stat_q   (stat_q),
  .en_q     (en_q),
  .evt_vec  (evt_vec),
  .clr_vec  (clr_vec),
  .susp_evt (susp_evt),
  .in_susp  (in_susp)
);

// File: tb/test_usbev_irq_reg.sv
module test_usbev_irq_reg;
  localparam int CPU = 2, SE0U = 10, IDLEU = 15;
  localparam int SE0_LIM = CPU * SE0U;    // 20
  localparam int IDLE_LIM = CPU * IDLEU;  // 30
  localparam logic [1:0] SE0 = 2'd0, J = 2'd1, K = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] line_st = K;
  logic vbus_pulse = 0, dline_pulse = 0, srp_sel_dline = 0;
  logic rconn = 0, bsess_vld = 0, asess_vld = 1, otg_tmr_expire = 0;
  logic reg_wr = 0, reg_addr = 0;
  logic [15:0] reg_wdata = 16'h0000;
  logic [15:0] reg_rdata;
  logic irq;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  usbev_irq_reg #(.CYC_PER_US(CPU), .SE0_US(SE0U), .IDLE_US(IDLEU)) i_usbev_irq_reg (
    .clk(clk), .rst_n(rst_n), .line_st(line_st), .vbus_pulse(vbus_pulse),
    .dline_pulse(dline_pulse), .srp_sel_dline(srp_sel_dline), .rconn(rconn),
    .bsess_vld(bsess_vld), .asess_vld(asess_vld), .otg_tmr_expire(otg_tmr_expire),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge
  int se0_run = 0, idle_run = 0;
  bit m_susp = 0, m_primed = 0;
  logic [15:0] m_stat = 0, m_en = 0;
  logic [1:0] m_prev = J;
  logic [2:0] m_prev_sts = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      se0_run = 0; idle_run = 0; m_susp = 0; m_primed = 0;
      m_stat = 0; m_en = 0; m_prev = J; m_prev_sts = 0;
    end else begin
      logic [15:0] ev, clr;
      logic [2:0] sts;
      bit enter;
      ev = 0; enter = 0;
      sts = {rconn, bsess_vld, asess_vld};
      if (otg_tmr_expire) ev[10] = 1;
      if (line_st == SE0) begin se0_run++; if (se0_run == SE0_LIM + 1) ev[9] = 1; end
      else se0_run = 0;
      if (srp_sel_dline ? dline_pulse : vbus_pulse) ev[8] = 1;
      if (m_susp && m_prev == J && line_st == K) ev[7] = 1;
      if (line_st == J) begin idle_run++; if (idle_run == IDLE_LIM + 1) begin ev[6] = 1; enter = 1; end end
      else idle_run = 0;
      if (m_primed) begin
        if (sts[2] != m_prev_sts[2]) ev[5] = 1;
        if (sts[1] != m_prev_sts[1]) ev[4] = 1;
        if (sts[0] != m_prev_sts[0]) ev[3] = 1;
      end
      if (enter) m_susp = 1; else if (line_st != J) m_susp = 0;
      clr = (reg_wr && !reg_addr) ? (reg_wdata & 16'h07F8) : 16'h0;
      m_stat = (m_stat & ~clr) | ev;
      if (reg_wr && reg_addr) m_en = reg_wdata & 16'h07F8;
      m_prev = line_st; m_prev_sts = sts; m_primed = 1;
    end
  end

  always @(negedge clk) begin
    logic [15:0] exp;
    exp = reg_addr ? m_en : m_stat;
    chk(reg_rdata == exp, "R12 model compare rdata", reg_rdata, exp);
    chk(irq == |(m_stat & m_en), "R11 model compare irq", {15'd0, irq}, {15'd0, |(m_stat & m_en)});
  end

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 0; reg_addr = 0; reg_wdata = 0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    #1 reg_addr = 0;
  endtask

  task automatic pulse_tmr();
    otg_tmr_expire = 1; cyc(); otg_tmr_expire = 0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    cyc(3);
    @(negedge clk);
    chk(reg_rdata == 0 && irq == 0, "R1 reset state", reg_rdata, 16'h0);
    @(posedge clk); #1 rst_n = 1;
    cyc(3);
    rd(0, d); chk(d[3] == 0, "R9 no flag after reset capture", d, 16'h0);
    rd(1, d); chk(d == 0, "R1 enable zero", d, 16'h0);

    // R11 enable register
    wr(1, 16'hFFFF);
    rd(1, d); chk(d == 16'h07F8, "R11 enable readback", d, 16'h07F8);
    rd(0, d); chk(irq == 0, "R11 irq low with no flags", {15'd0, irq}, 16'h0);

    // R10 timer
    pulse_tmr();
    rd(0, d); chk(d == 16'h0400, "R10 timer bit", d, 16'h0400);
    chk(irq == 1, "R11 irq high", {15'd0, irq}, 16'h1);
    wr(0, 16'h0000);
    rd(0, d); chk(d == 16'h0400, "R2 write zero keeps", d, 16'h0400);
    wr(0, 16'h0400);
    rd(0, d); chk(d == 16'h0000, "R2 write one clears", d, 16'h0);
    chk(irq == 0, "R11 irq drops", {15'd0, irq}, 16'h0);

    // R3 event vs clear in same cycle
    pulse_tmr();
    otg_tmr_expire = 1; wr(0, 16'h0400); otg_tmr_expire = 0;
    rd(0, d); chk(d == 16'h0400, "R3 event beats clear", d, 16'h0400);
    wr(0, 16'h0400);

    // R4 SE0 dwell
    line_st = SE0; cyc(15); line_st = J; cyc(); line_st = SE0; cyc(15); line_st = K; cyc();
    rd(0, d); chk(d[9] == 0, "R4 interrupted SE0 no flag", d, 16'h0);
    line_st = SE0; cyc(SE0_LIM);
    rd(0, d); chk(d[9] == 0, "R4 at limit no flag", d, 16'h0);
    cyc();
    rd(0, d); chk(d[9] == 1, "R4 beyond limit flag", d, 16'h0200);
    wr(0, 16'h0200); cyc(10);
    rd(0, d); chk(d[9] == 0, "R4 once per run", d, 16'h0);
    line_st = K; cyc();

    // R6 K after J while not suspended
    line_st = J; cyc(5); line_st = K; cyc();
    rd(0, d); chk(d[7] == 0, "R6 no resume unsuspended", d, 16'h0);

    // R5 idle to suspend
    line_st = J; cyc(IDLE_LIM);
    rd(0, d); chk(d[6] == 0, "R5 at limit no flag", d, 16'h0);
    cyc();
    rd(0, d); chk(d[6] == 1, "R5 suspend flag", d, 16'h0040);
    wr(0, 16'h0040); cyc(40);
    rd(0, d); chk(d[6] == 0, "R7 one suspend per entry", d, 16'h0);
    line_st = K; cyc();
    rd(0, d); chk(d[7] == 1, "R6 resume while suspended", d, 16'h0080);
    wr(0, 16'h0080);

    // R7 re-entry, then exit by SE0 without resume
    line_st = J; cyc(IDLE_LIM + 1);
    rd(0, d); chk(d[6] == 1, "R7 suspend again after exit", d, 16'h0040);
    line_st = SE0; cyc(); line_st = J; cyc(); line_st = K; cyc();
    rd(0, d); chk(d[7] == 0, "R7 SE0 left suspend", d, 16'h0040);
    wr(0, 16'h07F8);

    // R8 SRP selection
    srp_sel_dline = 0; dline_pulse = 1; cyc(); dline_pulse = 0;
    rd(0, d); chk(d[8] == 0, "R8 unselected dline ignored", d, 16'h0);
    vbus_pulse = 1; cyc(); vbus_pulse = 0;
    rd(0, d); chk(d[8] == 1, "R8 vbus selected", d, 16'h0100);
    wr(0, 16'h0100);
    srp_sel_dline = 1; vbus_pulse = 1; cyc(); vbus_pulse = 0;
    rd(0, d); chk(d[8] == 0, "R8 unselected vbus ignored", d, 16'h0);
    dline_pulse = 1; cyc(); dline_pulse = 0;
    rd(0, d); chk(d[8] == 1, "R8 dline selected", d, 16'h0100);
    wr(0, 16'h0100);

    // R9 toggles
    rconn = 1; cyc();
    rd(0, d); chk(d == 16'h0020, "R9 rconn rise", d, 16'h0020);
    wr(0, 16'h0020); rconn = 0; cyc();
    rd(0, d); chk(d == 16'h0020, "R9 rconn fall", d, 16'h0020);
    wr(0, 16'h0020);
    bsess_vld = 1; cyc();
    rd(0, d); chk(d == 16'h0010, "R9 bsess toggle", d, 16'h0010);
    wr(0, 16'h0010); asess_vld = 0; cyc();
    rd(0, d); chk(d == 16'h0008, "R9 asess toggle", d, 16'h0008);

    // R11 masked source
    wr(1, 16'h0010);
    rd(0, d); chk(irq == 0, "R11 disabled bit no irq", {15'd0, irq}, 16'h0);
    wr(1, 16'h0008);
    rd(0, d); chk(irq == 1, "R11 enabled bit irq", {15'd0, irq}, 16'h1);
    cyc(4);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule